// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block is the host-facing register set of one bus-master DMA channel. The host reaches three registers through a small byte-lane access port: a command register, a status register and a descriptor-table base pointer. From them the block drives the channel's control side. It issues a one-cycle start strobe and a one-cycle cancel strobe, presents the stored direction bit, and presents both the table base and the current table pointer to a separate descriptor walker. The walker reports back when it finishes, whether more data is pending, and whether an error occurred.

Start and stop are edge actions. Only a command write that changes the stored start bit does anything. Writing the same value again is quiet. The block also sits in the drive's interrupt path. A high level on the drive interrupt input is forwarded to the host at once and is latched into a sticky status bit. A low level is forwarded as well, but it leaves the latched bit alone. Software then clears the bit by writing 1 to it.

Register select encoding on `host_sel`: 0 is command, 1 is status, 2 is table base, and 3 selects nothing (reads 0, writes ignored). Access size encoding on `host_size`: 0 is one byte, 1 is two bytes, 2 and 3 are four bytes. Reads are combinational from the current state.

Top module: `dma_busmaster_regs`

## Requirements
- R1: A command write (select 0, offset 0) stores bit 0 (start) and bit 3 (direction) of `host_wdata`. Reading the command register at offset 0 returns those two bits in place and zeros elsewhere. Command or status writes at a nonzero offset are ignored, and reads there return 0.
- R2: A command write whose bit 0 equals the stored start bit raises neither strobe and does not change the active bit.
- R3: A command write that changes start from 1 to 0 pulses `cancel_pulse` for one cycle in the cycle after the write and clears status bit 0 (active).
- R4: A command write that changes start from 0 to 1 loads `cur_ptr` from the table base. If active was 0, it sets active and pulses `start_pulse` for one cycle in the cycle after the write. If active was already 1, no start strobe is issued.
- R5: A table-base write (select 2) of 1, 2 or 4 bytes at byte offset 0 to 3 replaces only the addressed bytes (bytes beyond bit 31 are dropped), and base bits 1:0 always read as 0. The new value appears on `tbl_base` in the cycle after the write.
- R6: A table-base read returns the base shifted right by 8 times the offset, masked to the access width.
- R7: While `drv_irq` is high, `host_irq` is high in the same cycle and status bit 2 (interrupt) is set after the next clock edge.
- R8: While `drv_irq` is low, `host_irq` is low and status bit 2 keeps its value unless software clears it.
- R9: A status write (select 1, offset 0) with bit 1 or bit 2 set clears the error or interrupt bit respectively. A set request in the same cycle (`walk_err`, `drv_irq`) wins over the clear. Status bit 0 cannot be written. Status reads as {interrupt, error, active} in bits 2:0.
- R10: `walk_done` clears active, or sets it when `walk_more` is high. A command write that changes the start bit in the same cycle takes precedence.
- R11: Reset (synchronous, active low) clears command, status, table base and current pointer, and holds both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write enable for the selected register |
| host_sel | input | 2 | Register select: 0 command, 1 status, 2 table base, 3 none |
| host_off | input | OFF_W (2) | Byte offset within the selected register |
| host_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2/3 four bytes |
| host_wdata | input | ADDR_W (32) | Write data, least significant byte first |
| host_rdata | output | ADDR_W (32) | Read data for the current select, offset and size |
| drv_irq | input | 1 | Interrupt level from the attached drive |
| host_irq | output | 1 | Interrupt level forwarded to the host |
| walk_done | input | 1 | Walker finished a transfer step |
| walk_more | input | 1 | Qualifies walk_done: more data pending, stay active |
| walk_err | input | 1 | Walker error, sets status bit 1 |
| start_pulse | output | 1 | One-cycle request to begin walking the table |
| cancel_pulse | output | 1 | One-cycle request to abort the transfer |
| xfer_dir | output | 1 | Stored direction bit |
| tbl_base | output | ADDR_W (32) | Descriptor table base pointer |
| cur_ptr | output | ADDR_W (32) | Current table pointer, loaded on start |

## Verification
A wrong stored start bit does not show on its own. It shows on the next command write, which then gives a missing or spurious strobe one cycle after the write, so the bench writes random start values and compares both strobes on every cycle. A wrong active, error or interrupt bit shows on any status read in the same cycle, and on the start strobe of the next rising start write. Corrupted base lanes show on `tbl_base` one cycle after the write, and on reads of any offset and width. These are checked after each random byte-lane write, and `cur_ptr` is checked after every start.

// File: rtl/dma_busmaster_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bus-master DMA register file.
// Assumes a host port that selects one register per access.
package dma_busmaster_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BASE = 2'd2,
        SEL_NONE = 2'd3
    } dcr_sel_e;

    // Command register bit positions (software decodes these).
    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 3;

    // Status register bit positions.
    localparam int STAT_ACT_BIT = 0;
    localparam int STAT_ERR_BIT = 1;
    localparam int STAT_IRQ_BIT = 2;

    // Access size code to byte count.
    function automatic logic [2:0] acc_bytes(input logic [1:0] size_code);
        case (size_code)
            2'd0:    acc_bytes = 3'd1;
            2'd1:    acc_bytes = 3'd2;
            default: acc_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dcr_cmd_ctl.sv
`timescale 1ns/1ps
// Command register and channel activity control.
// Stores start and direction, turns start-bit changes into one-cycle
// strobes, and tracks the active bit against walker completions.
// Assumes cmd_wr is already qualified to offset 0 of the command register.
module dcr_cmd_ctl
    import dma_busmaster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_wdata,
    input  logic       walk_done,
    input  logic       walk_more,
    output logic       go_q,
    output logic       dir_q,
    output logic       active_q,
    output logic       start_pulse,
    output logic       cancel_pulse,
    output logic       reload
);

    logic new_go;
    logic flip;
    logic rise;
    logic fall;

    // Detect a change of the stored start bit.
    always_comb begin
        new_go = cmd_wdata[CMD_GO_BIT];
        flip   = cmd_wr && (new_go != go_q);
        rise   = flip && new_go;
        fall   = flip && !new_go;
    end

    assign reload = rise;

    // Register command bits, strobes and the active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q         <= 1'b0;
            dir_q        <= 1'b0;
            active_q     <= 1'b0;
            start_pulse  <= 1'b0;
            cancel_pulse <= 1'b0;
        end else begin
            start_pulse  <= rise && !active_q;
            cancel_pulse <= fall;
            if (cmd_wr) begin
                go_q  <= new_go;
                dir_q <= cmd_wdata[CMD_DIR_BIT];
            end
            if (fall) begin
                active_q <= 1'b0;
            end else if (rise) begin
                active_q <= 1'b1;
            end else if (walk_done) begin
                active_q <= walk_more;
            end
        end
    end

    a_r1_dir_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (dir_q == $past(cmd_wdata[CMD_DIR_BIT])));

    a_r2_same_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd_wdata[CMD_GO_BIT] == go_q)) |=> (!start_pulse && !cancel_pulse));

    a_r3_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_wdata[CMD_GO_BIT] && go_q) |=> (cancel_pulse && !active_q));

    a_r4_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[CMD_GO_BIT] && !go_q) |=> active_q);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[CMD_GO_BIT] && !go_q && active_q) |=> !start_pulse);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_more && !cmd_wr) |=> !active_q);

    a_r10_more_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_more && !cmd_wr) |=> active_q);

endmodule

// File: rtl/dcr_base_reg.sv
`timescale 1ns/1ps
// Descriptor-table base pointer with byte-lane writes and reads,
// plus the current table pointer that is loaded on each start.
// Assumes ADDR_W is a multiple of 8; low ALIGN_BITS of the base are zero.
module dcr_base_reg
    import dma_busmaster_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int OFF_W      = $clog2(ADDR_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [OFF_W-1:0]  base_off,
    input  logic [1:0]        base_size,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              reload,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] cur_q,
    output logic [ADDR_W-1:0] base_rdata
);

    localparam int NLANES = ADDR_W / 8;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

    logic [2:0]        nbytes;
    logic [ADDR_W-1:0] wr_shift;
    logic [ADDR_W-1:0] next_base;
    logic [ADDR_W-1:0] rd_mask;
    logic [NLANES-1:0] lane_hit;

    assign nbytes   = acc_bytes(base_size);
    assign wr_shift = base_wdata << (8 * base_off);

    // Per-lane write select and read mask.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign lane_hit[g] = base_wr && (int'(base_off) <= g)
                             && (g < int'(base_off) + int'(nbytes));
        assign next_base[8*g +: 8] = lane_hit[g] ? wr_shift[8*g +: 8]
                                                 : base_q[8*g +: 8];
        assign rd_mask[8*g +: 8]   = (g < int'(nbytes)) ? 8'hFF : 8'h00;
    end

    // Read view: addressed bytes shifted down and trimmed to the width.
    assign base_rdata = (base_q >> (8 * base_off)) & rd_mask;

    // Hold the aligned base and load the current pointer on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_wr) begin
                base_q <= next_base & ~LOW_MASK;
            end
            if (reload) begin
                cur_q <= base_q;
            end
        end
    end

    a_r5_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && (base_off == '0) && (base_size == 2'd0))
        |=> (base_q[ADDR_W-1:8] == $past(base_q[ADDR_W-1:8])));

    a_r5_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> $stable(base_q));

    a_r4_reload_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cur_q == $past(base_q)));

endmodule

// File: rtl/dcr_irq_stat.sv
`timescale 1ns/1ps
// Sticky interrupt and error status bits with write-1-to-clear,
// and the pass-through of the drive interrupt to the host.
// Assumes stat_wr is already qualified to offset 0 of the status register.
module dcr_irq_stat
    import dma_busmaster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_irq,
    input  logic       walk_err,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    output logic       irq_q,
    output logic       err_q,
    output logic       host_irq
);

    // Forward the drive level unchanged in both directions.
    assign host_irq = drv_irq;

    // Latch on set requests, clear on a write of 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (drv_irq) begin
                irq_q <= 1'b1;
            end else if (stat_wr && stat_wdata[STAT_IRQ_BIT]) begin
                irq_q <= 1'b0;
            end
            if (walk_err) begin
                err_q <= 1'b1;
            end else if (stat_wr && stat_wdata[STAT_ERR_BIT]) begin
                err_q <= 1'b0;
            end
        end
    end

    a_r7_irq_latch: assert property (@(posedge clk) disable iff (!rst_n)
        drv_irq |=> irq_q);

    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_irq && !(stat_wr && stat_wdata[STAT_IRQ_BIT]))
        |=> (irq_q == $past(irq_q)));

    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata[STAT_ERR_BIT] && !walk_err) |=> !err_q);

    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |=> err_q);

endmodule

// File: rtl/dma_busmaster_regs.sv
`timescale 1ns/1ps
// Host register file of one bus-master DMA channel.
// Decodes host accesses to command, status and table-base registers,
// drives start/cancel strobes to a descriptor walker and forwards the
// drive interrupt. Assumes one register is selected per access.
module dma_busmaster_regs
    import dma_busmaster_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int OFF_W      = $clog2(ADDR_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] host_rdata,
    input  logic              drv_irq,
    output logic              host_irq,
    input  logic              walk_done,
    input  logic              walk_more,
    input  logic              walk_err,
    output logic              start_pulse,
    output logic              cancel_pulse,
    output logic              xfer_dir,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] cur_ptr
);

    dcr_sel_e          sel_e;
    logic              off_zero;
    logic              cmd_wr;
    logic              stat_wr;
    logic              base_wr;
    logic              go_q;
    logic              dir_q;
    logic              active_q;
    logic              reload;
    logic              irq_q;
    logic              err_q;
    logic [ADDR_W-1:0] base_rdata;

    // Decode the host access into per-register write enables.
    always_comb begin
        sel_e    = dcr_sel_e'(host_sel);
        off_zero = (host_off == '0);
        cmd_wr   = host_wr && (sel_e == SEL_CMD)  && off_zero;
        stat_wr  = host_wr && (sel_e == SEL_STAT) && off_zero;
        base_wr  = host_wr && (sel_e == SEL_BASE);
    end

    dcr_cmd_ctl u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_wdata    (host_wdata[7:0]),
        .walk_done    (walk_done),
        .walk_more    (walk_more),
        .go_q         (go_q),
        .dir_q        (dir_q),
        .active_q     (active_q),
        .start_pulse  (start_pulse),
        .cancel_pulse (cancel_pulse),
        .reload       (reload)
    );

    dcr_base_reg #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS),
        .OFF_W      (OFF_W)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_off   (host_off),
        .base_size  (host_size),
        .base_wdata (host_wdata),
        .reload     (reload),
        .base_q     (tbl_base),
        .cur_q      (cur_ptr),
        .base_rdata (base_rdata)
    );

    dcr_irq_stat u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .drv_irq    (drv_irq),
        .walk_err   (walk_err),
        .stat_wr    (stat_wr),
        .stat_wdata (host_wdata[7:0]),
        .irq_q      (irq_q),
        .err_q      (err_q),
        .host_irq   (host_irq)
    );

    assign xfer_dir = dir_q;

    // Read multiplexer over the three registers.
    always_comb begin
        host_rdata = '0;
        unique case (sel_e)
            SEL_CMD: begin
                if (off_zero) begin
                    host_rdata[CMD_GO_BIT]  = go_q;
                    host_rdata[CMD_DIR_BIT] = dir_q;
                end
            end
            SEL_STAT: begin
                if (off_zero) begin
                    host_rdata[STAT_ACT_BIT] = active_q;
                    host_rdata[STAT_ERR_BIT] = err_q;
                    host_rdata[STAT_IRQ_BIT] = irq_q;
                end
            end
            SEL_BASE: host_rdata = base_rdata;
            default:  host_rdata = '0;
        endcase
    end

    a_r9_active_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !walk_done) |=> (active_q == $past(active_q)));

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && cancel_pulse));

endmodule

// File: tb/dma_busmaster_regs_bench.sv
`timescale 1ns/1ps
// Self-checking bench: random register traffic plus directed corners,
// compared each cycle against a bench-side reference model.
module dma_busmaster_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [1:0]  host_off = 2'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        drv_irq = 1'b0;
    logic        host_irq;
    logic        walk_done = 1'b0;
    logic        walk_more = 1'b0;
    logic        walk_err = 1'b0;
    logic        start_pulse;
    logic        cancel_pulse;
    logic        xfer_dir;
    logic [31:0] tbl_base;
    logic [31:0] cur_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    bit          m_start, m_dir, m_act, m_err, m_irq;
    logic [31:0] m_base, m_cur;
    logic [31:0] last_rd;

    always #2.5 clk = ~clk;

    dma_busmaster_regs u_dma_busmaster_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_sel     (host_sel),
        .host_off     (host_off),
        .host_size    (host_size),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .drv_irq      (drv_irq),
        .host_irq     (host_irq),
        .walk_done    (walk_done),
        .walk_more    (walk_more),
        .walk_err     (walk_err),
        .start_pulse  (start_pulse),
        .cancel_pulse (cancel_pulse),
        .xfer_dir     (xfer_dir),
        .tbl_base     (tbl_base),
        .cur_ptr      (cur_ptr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int size_n(input logic [1:0] sz);
        case (sz)
            2'd0:    size_n = 1;
            2'd1:    size_n = 2;
            default: size_n = 4;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] sel, input logic [1:0] off,
                                               input logic [1:0] sz);
        logic [31:0] v;
        v = '0;
        if (sel == 2'd0 && off == 2'd0) begin
            v[0] = m_start;
            v[3] = m_dir;
        end else if (sel == 2'd1 && off == 2'd0) begin
            v[2:0] = {m_irq, m_err, m_act};
        end else if (sel == 2'd2) begin
            v = (m_base >> (8 * off)) & size_mask(sz);
        end
        return v;
    endfunction

    function automatic string rd_tag(input logic [1:0] sel);
        case (sel)
            2'd0:    rd_tag = "R1 command readback";
            2'd1:    rd_tag = "R9 status readback";
            2'd2:    rd_tag = "R6 base read";
            default: rd_tag = "R1 unmapped read";
        endcase
    endfunction

    // One clock cycle: inputs already driven; check reads, advance model, check outputs.
    task automatic step();
        bit          cmdw, statw, basew, flip, e_sp, e_cp, nact;
        logic [31:0] nb;
        #1;
        last_rd = host_rdata;
        chk(rd_tag(host_sel), host_rdata, model_read(host_sel, host_off, host_size));
        if (drv_irq) chk("R7 irq forward", 32'(host_irq), 32'd1);
        else         chk("R8 irq forward", 32'(host_irq), 32'd0);

        cmdw  = host_wr && host_sel == 2'd0 && host_off == 2'd0;
        statw = host_wr && host_sel == 2'd1 && host_off == 2'd0;
        basew = host_wr && host_sel == 2'd2;
        flip  = cmdw && (host_wdata[0] != m_start);
        e_sp = 0; e_cp = 0; nact = m_act;
        if (flip && !host_wdata[0]) begin
            e_cp = 1; nact = 0;
        end else if (flip && host_wdata[0]) begin
            m_cur = m_base;
            if (!m_act) begin nact = 1; e_sp = 1; end
        end else if (walk_done) begin
            nact = walk_more;
        end
        m_act = nact;
        if (cmdw) begin m_start = host_wdata[0]; m_dir = host_wdata[3]; end
        if (walk_err) m_err = 1; else if (statw && host_wdata[1]) m_err = 0;
        if (drv_irq)  m_irq = 1; else if (statw && host_wdata[2]) m_irq = 0;
        if (basew) begin
            nb = m_base;
            for (int i = 0; i < 4; i++) begin
                if (i >= int'(host_off) && i < int'(host_off) + size_n(host_size))
                    nb[8*i +: 8] = host_wdata[8*(i - int'(host_off)) +: 8];
            end
            nb[1:0] = 2'b00;
            m_base = nb;
        end

        @(posedge clk);
        @(negedge clk);
        chk("R4 start strobe", 32'(start_pulse), 32'(e_sp));
        chk("R3 cancel strobe", 32'(cancel_pulse), 32'(e_cp));
        chk("R1 direction bit", 32'(xfer_dir), 32'(m_dir));
        chk("R5 base register", tbl_base, m_base);
        chk("R4 current pointer", cur_ptr, m_cur);
    endtask

    task automatic set_idle();
        host_wr = 0; walk_done = 0; walk_more = 0; walk_err = 0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [1:0] off, input logic [1:0] sz,
                          input logic [31:0] wd);
        set_idle();
        host_wr = 1; host_sel = sel; host_off = off; host_size = sz; host_wdata = wd;
        step();
        host_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, input logic [1:0] off, input logic [1:0] sz);
        set_idle();
        host_sel = sel; host_off = off; host_size = sz;
        step();
    endtask

    task automatic walker(input bit done, input bit more, input bit err);
        set_idle();
        walk_done = done; walk_more = more; walk_err = err;
        step();
        set_idle();
    endtask

    task automatic do_reset();
        set_idle();
        drv_irq = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0;
        m_base = '0; m_cur = '0;
        chk("R11 reset start strobe", 32'(start_pulse), 32'd0);
        chk("R11 reset cancel strobe", 32'(cancel_pulse), 32'd0);
        chk("R11 reset base", tbl_base, 32'd0);
        chk("R11 reset current pointer", cur_ptr, 32'd0);
        chk("R11 reset direction", 32'(xfer_dir), 32'd0);
        rst_n = 1;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R11: every register reads zero after reset
        rd_reg(2'd0, 2'd0, 2'd0); chk("R11 command after reset", last_rd, 32'h0);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R11 status after reset", last_rd, 32'h0);
        rd_reg(2'd2, 2'd0, 2'd2); chk("R11 base after reset", last_rd, 32'h0);

        // R5 / R6: byte-lane base writes and reads
        wr_reg(2'd2, 2'd0, 2'd2, 32'hDEAD_BEEF);
        chk("R5 full write low bits forced", tbl_base, 32'hDEAD_BEEC);
        wr_reg(2'd2, 2'd2, 2'd0, 32'h0000_0055);
        chk("R5 byte lane 2 write", tbl_base, 32'hDE55_BEEC);
        wr_reg(2'd2, 2'd1, 2'd1, 32'h0000_1234);
        chk("R5 halfword at offset 1", tbl_base, 32'hDE12_34EC);
        wr_reg(2'd2, 2'd3, 2'd2, 32'h0000_00A7);
        chk("R5 wide write past top drops bytes", tbl_base, 32'hA712_34EC);
        rd_reg(2'd2, 2'd2, 2'd1); chk("R6 halfword read offset 2", last_rd, 32'h0000_A712);
        rd_reg(2'd2, 2'd3, 2'd0); chk("R6 byte read offset 3", last_rd, 32'h0000_00A7);
        rd_reg(2'd2, 2'd1, 2'd2); chk("R6 word read offset 1", last_rd, 32'h00A7_1234);

        // R1 / R4: start with all bits set; only start and direction kept
        wr_reg(2'd0, 2'd0, 2'd0, 32'h0000_00FF);
        chk("R4 start strobe on 0 to 1", 32'(start_pulse), 32'd1);
        chk("R4 pointer reload", cur_ptr, 32'hA712_34EC);
        rd_reg(2'd0, 2'd0, 2'd0); chk("R1 only bits 0 and 3 kept", last_rd, 32'h0000_0009);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R4 active set", last_rd, 32'h0000_0001);

        // R2: same start bit again is quiet
        wr_reg(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        chk("R2 no start strobe", 32'(start_pulse), 32'd0);
        chk("R2 no cancel strobe", 32'(cancel_pulse), 32'd0);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R2 active unchanged", last_rd, 32'h0000_0001);

        // R1: nonzero offset command write ignored
        wr_reg(2'd0, 2'd1, 2'd0, 32'h0000_0000);
        chk("R1 offset write ignored", 32'(cancel_pulse), 32'd0);

        // R3: stop
        wr_reg(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        chk("R3 cancel strobe on 1 to 0", 32'(cancel_pulse), 32'd1);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R3 active cleared", last_rd, 32'h0000_0000);

        // R10 + R4: walker leaves active set, then start gives no strobe
        walker(1, 1, 0);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R10 more keeps active", last_rd, 32'h0000_0001);
        wr_reg(2'd2, 2'd0, 2'd2, 32'h1000_2000);
        wr_reg(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        chk("R4 no strobe when already active", 32'(start_pulse), 32'd0);
        chk("R4 pointer reload while active", cur_ptr, 32'h1000_2000);
        walker(1, 0, 0);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R10 done clears active", last_rd, 32'h0000_0000);

        // R7 / R8 / R9: interrupt latch and write-1-to-clear
        drv_irq = 1;
        rd_reg(2'd1, 2'd0, 2'd0);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R7 interrupt latched", last_rd, 32'h0000_0004);
        drv_irq = 0;
        rd_reg(2'd1, 2'd0, 2'd0); chk("R8 interrupt held after drop", last_rd, 32'h0000_0004);
        walker(0, 0, 1);
        wr_reg(2'd1, 2'd0, 2'd0, 32'h0000_0001);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R9 active not writable", last_rd, 32'h0000_0006);
        wr_reg(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R9 interrupt cleared", last_rd, 32'h0000_0002);
        wr_reg(2'd1, 2'd0, 2'd0, 32'h0000_0002);
        rd_reg(2'd1, 2'd0, 2'd0); chk("R9 error cleared", last_rd, 32'h0000_0000);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 8);
            set_idle();
            host_sel   = 2'($urandom % 4);
            host_off   = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'd0;
            host_size  = 2'($urandom % 4);
            host_wdata = $urandom;
            case (op)
                0, 1: begin host_wr = 1; host_sel = 2'd0; end
                2:    begin host_wr = 1; host_sel = 2'd1; end
                3, 4: begin host_wr = 1; host_sel = 2'd2; host_off = 2'($urandom % 4); end
                default: host_wr = 0;
            endcase
            walk_done = ($urandom % 6 == 0);
            walk_more = $urandom % 2;
            walk_err  = ($urandom % 20 == 0);
            if ($urandom % 5 == 0) drv_irq = ~drv_irq;
            step();
            if (n == 1500) do_reset();
        end

        // R11: reset after traffic
        do_reset();
        rd_reg(2'd1, 2'd0, 2'd0); chk("R11 status after late reset", last_rd, 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule